// File: doc/BRIEF.md
# Dual-Lane Serial Result Shifter

This block is the serial readout stage of an eight-channel sampling converter. It captures the 16-bit result words when a conversion finishes. While the host holds chip-select low, it presents them most significant bit first on two serial data lines. The host supplies a serial clock that idles high. Each falling edge of that clock moves both lanes to their next bit, and the host samples on the rising edge. Lane A carries the lower half of the channels and lane B carries the upper half. When the host wires up only lane A, a lane-count setting makes lane A run through every channel in ascending order.

All inputs, including the host's serial clock and chip-select, are treated as synchronous to the fabric clock `clk`. The block detects the edges of chip-select and the serial clock by comparing each one with its value in the previous cycle. Serial readout is enabled only when the mode strap is high and the byte strap is low. A first-data flag marks the bits of channel 1.

Top module: `dual_lane_shifter`

## Requirements
- R1: Readout runs only when `mode_sel`=1 and `byte_sel`=0. In any other strap combination, `dout_a`, `dout_b` and `first_data` stay 0, and serial clock edges have no effect.
- R2: While `cs_n` is high, `dout_a`, `dout_b` and `first_data` are 0. A rising `cs_n` abandons the frame, so the next frame restarts at channel 1, bit 15.
- R3: One cycle after a falling `cs_n`, lane A shows bit 15 of channel 1 and lane B shows bit 15 of channel NUM_CH/2+1. Lane B does this only in two-lane mode.
- R4: Each falling `sclk` edge while a frame is active advances both lanes by one bit. Bits leave from bit 15 down to bit 0, 16 bits per channel, with channels ascending.
- R5: Two-lane mode (`one_lane`=0): lane A carries channels 1..NUM_CH/2 and lane B carries channels NUM_CH/2+1..NUM_CH, each over NUM_CH/2*16 bits.
- R6: Single-lane mode (`one_lane`=1): lane A carries channels 1..NUM_CH in ascending order over NUM_CH*16 bits, and `dout_b` stays 0.
- R7: After a lane's last bit, that lane outputs 0, and further `sclk` edges in the same frame change nothing.
- R8: `first_data` is 1 from the frame start until the 16th falling `sclk` edge, then 0 for the rest of the frame.
- R9: `results` is captured only on a falling `busy`. Changes to `results` at any other time, including while `busy` is high, do not alter the bits read out.
- R10: After reset, `dout_a`, `dout_b` and `first_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Mode strap; must be 1 for serial readout |
| byte_sel | input | 1 | Byte strap; must be 0 for serial readout |
| one_lane | input | 1 | 1 = lane A only, 0 = both lanes |
| busy | input | 1 | Conversion in progress; falling edge captures results |
| cs_n | input | 1 | Active-low chip-select framing a readout |
| sclk | input | 1 | Host serial clock, idles high, bits advance on its falling edge |
| results | input | NUM_CH*WORD_W | Result words, channel 1 in the lowest WORD_W bits |
| dout_a | output | 1 | Serial data lane A |
| dout_b | output | 1 | Serial data lane B |
| first_data | output | 1 | High while channel 1 bits are shifted |

## Verification
A bit counter that is off by one shows up at the first rising sample of a frame. The data lines then present the wrong bit of channel 1, and `first_data` falls one edge early or late. A fault in channel selection shows up at the first channel boundary, 16 edges into the frame, as the wrong word on a lane. A fault in single-lane continuation shows up 64 edges in. A missed capture or a stray capture of `results` shows up as stale or early data on the very first bit that differs between the two patterns. The bench compares every sampled bit of both lanes, in both lane modes and past the end of the frame, against words it computes itself.

// File: rtl/dls_pkg.sv
package dls_pkg;

    typedef enum int {
        LANE_A = 0,
        LANE_B = 1
    } lane_e;

    function automatic logic serial_selected(input logic mode_strap, input logic byte_strap);
        return mode_strap && !byte_strap;
    endfunction

endpackage

// File: rtl/dls_capture.sv
module dls_capture #(
    parameter int NUM_CH = 8,
    parameter int WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     busy,
    input  logic [NUM_CH*WORD_W-1:0] results,
    output logic [NUM_CH*WORD_W-1:0] store_q
);
    localparam int STORE_W = NUM_CH * WORD_W;

    typedef struct packed {
        logic               busy;
        logic [STORE_W-1:0] store;
    } cap_t;

    cap_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.busy = busy;
        if (c_q.busy && !busy) begin
            c_d.store = results;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign store_q = c_q.store;

    // R9: stored words move only on a falling busy
    p_store_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(c_q.busy && !busy) |=> $stable(c_q.store));

endmodule

// File: rtl/dls_sequencer.sv
module dls_sequencer #(
    parameter int NUM_CH = 8,
    parameter int WORD_W = 16,
    localparam int TOTAL = NUM_CH * WORD_W,
    localparam int POS_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_en,
    input  logic             cs_n,
    input  logic             sclk,
    output logic             active_q,
    output logic [POS_W-1:0] pos_q,
    output logic             first_data
);
    localparam logic [POS_W-1:0] POS_END   = POS_W'(TOTAL);
    localparam logic [POS_W-1:0] POS_FIRST = POS_W'(WORD_W);

    typedef struct packed {
        logic             cs;
        logic             sclk;
        logic             active;
        logic [POS_W-1:0] pos;
    } seq_t;

    seq_t s_d, s_q;
    logic sclk_fall;

    assign sclk_fall = s_q.sclk && !sclk;

    always_comb begin
        s_d      = s_q;
        s_d.cs   = cs_n;
        s_d.sclk = sclk;
        if (!ser_en || cs_n) begin
            s_d.active = 1'b0;
            s_d.pos    = '0;
        end else if (s_q.cs) begin
            s_d.active = 1'b1;
            s_d.pos    = '0;
        end else if (s_q.active && sclk_fall && s_q.pos != POS_END) begin
            s_d.pos = s_q.pos + POS_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cs     <= 1'b1;
            s_q.sclk   <= 1'b1;
            s_q.active <= 1'b0;
            s_q.pos    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_q   = s_q.active;
    assign pos_q      = s_q.pos;
    assign first_data = s_q.active && (s_q.pos < POS_FIRST);

    // R2: a high chip-select ends the frame
    p_cs_ends_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!s_q.active && s_q.pos == '0));

    // R1: straps off keep the sequencer idle
    p_straps_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> !s_q.active);

    // R4: no serial clock edge, no movement
    p_hold_no_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !cs_n && ser_en && !sclk_fall) |=> $stable(s_q.pos));

    // R4: one edge moves exactly one bit
    p_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !cs_n && ser_en && sclk_fall && s_q.pos != POS_END)
        |=> (s_q.pos == $past(s_q.pos) + POS_W'(1)));

    // R7: the position never runs past the end
    p_bounded_r7: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pos <= POS_END);

endmodule

// File: rtl/dls_lane.sv
module dls_lane #(
    parameter int           NUM_CH = 8,
    parameter int           WORD_W = 16,
    parameter dls_pkg::lane_e LANE = dls_pkg::LANE_A,
    localparam int TOTAL = NUM_CH * WORD_W,
    localparam int POS_W = $clog2(TOTAL + 1),
    localparam int IDX_W = $clog2(TOTAL)
) (
    input  logic                     active,
    input  logic [POS_W-1:0]         pos,
    input  logic                     one_lane,
    input  logic [TOTAL-1:0]         store,
    output logic                     dout
);
    localparam int HALF  = NUM_CH / 2;
    localparam int SPLIT = HALF * WORD_W;
    localparam int BASE  = (LANE == dls_pkg::LANE_B) ? HALF : 0;

    int               span;
    int               ch;
    int               bitpos;
    logic [IDX_W-1:0] idx;

    always_comb begin
        if (LANE == dls_pkg::LANE_A) begin
            span = one_lane ? TOTAL : SPLIT;
        end else begin
            span = one_lane ? 0 : SPLIT;
        end
        ch     = BASE + int'(pos) / WORD_W;
        bitpos = WORD_W - 1 - (int'(pos) % WORD_W);
        idx    = IDX_W'(ch * WORD_W + bitpos);
        dout   = 1'b0;
        if (active && int'(pos) < span) begin
            dout = store[idx];
        end
    end

endmodule

// File: rtl/dual_lane_shifter.sv
module dual_lane_shifter #(
    parameter int NUM_CH = 8,
    parameter int WORD_W = 16,
    localparam int TOTAL = NUM_CH * WORD_W,
    localparam int POS_W = $clog2(TOTAL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             byte_sel,
    input  logic             one_lane,
    input  logic             busy,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [TOTAL-1:0] results,
    output logic             dout_a,
    output logic             dout_b,
    output logic             first_data
);
    logic             ser_en;
    logic [TOTAL-1:0] store_q;
    logic             active_q;
    logic [POS_W-1:0] pos_q;
    logic [1:0]       lane_bit;

    assign ser_en = dls_pkg::serial_selected(mode_sel, byte_sel);

    dls_capture #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .results (results),
        .store_q (store_q)
    );

    dls_sequencer #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ser_en     (ser_en),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .active_q   (active_q),
        .pos_q      (pos_q),
        .first_data (first_data)
    );

    for (genvar g = 0; g < 2; g++) begin : g_lane
        dls_lane #(
            .NUM_CH (NUM_CH),
            .WORD_W (WORD_W),
            .LANE   (dls_pkg::lane_e'(g))
        ) u_lane (
            .active   (active_q),
            .pos      (pos_q),
            .one_lane (one_lane),
            .store    (store_q),
            .dout     (lane_bit[g])
        );
    end

    assign dout_a = lane_bit[0];
    assign dout_b = lane_bit[1];

    // R2: chip-select high quiets every output one cycle on
    p_cs_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout_a && !dout_b && !first_data));

    // R1: wrong strap setting quiets every output one cycle on
    p_strap_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> (!dout_a && !dout_b && !first_data));

    // R6: lane B is silent in single-lane mode
    p_lane_b_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        one_lane |-> !dout_b);

    // R8: the first-data flag never rises mid-frame
    p_first_no_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!first_data && !cs_n && ser_en && !$fell(cs_n)) |=> !first_data);

endmodule

// File: tb/dual_lane_shifter_test.sv
module dual_lane_shifter_test;
    localparam int NCH = 8;
    localparam int W   = 16;
    localparam int HALF = NCH / 2;

    logic clk = 1'b0;
    logic rst_n, mode_sel, byte_sel, one_lane, busy, cs_n, sclk;
    logic [NCH*W-1:0] results;
    logic dout_a, dout_b, first_data;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] exp_words [NCH];

    always #5 clk = ~clk;

    dual_lane_shifter #(.NUM_CH(NCH), .WORD_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .byte_sel(byte_sel),
        .one_lane(one_lane), .busy(busy), .cs_n(cs_n), .sclk(sclk),
        .results(results), .dout_a(dout_a), .dout_b(dout_b), .first_data(first_data)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] pattern(input int seed, input int ch);
        return W'(seed + ch * 16'h1357) ^ W'(ch << 11);
    endfunction

    task automatic drive_results(input int seed);
        for (int i = 0; i < NCH; i++) results[i*W +: W] = pattern(seed, i);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    // R9: pulse busy; the falling edge captures the current results
    task automatic convert(input int seed);
        @(negedge clk);
        drive_results(seed);
        busy = 1'b1;
        settle();
        busy = 1'b0;
        for (int i = 0; i < NCH; i++) exp_words[i] = pattern(seed, i);
        settle();
    endtask

    task automatic read_frame(input logic lane1, input int nbits, input logic ser);
        int span_a;
        string tag;
        logic ea, eb, ef;
        span_a = lane1 ? NCH * W : HALF * W;
        @(negedge clk);
        one_lane = lane1;
        cs_n = 1'b0;
        settle();
        for (int k = 0; k < nbits; k++) begin
            ea = 1'b0; eb = 1'b0; ef = 1'b0;
            if (ser) begin
                if (k < span_a) ea = exp_words[k / W][W - 1 - (k % W)];
                if (!lane1 && k < HALF * W) eb = exp_words[HALF + k / W][W - 1 - (k % W)];
                ef = (k < W);
            end
            if (!ser)                 tag = "R1";
            else if (k == 0)          tag = "R3";
            else if (k >= span_a)     tag = "R7";
            else if (lane1)           tag = "R6";
            else if (k % W == 0)      tag = "R4";
            else                      tag = "R5";
            chk(tag, $sformatf("dout_a bit %0d lane1=%0b", k, lane1), dout_a, ea);
            chk(lane1 ? "R6" : tag, $sformatf("dout_b bit %0d lane1=%0b", k, lane1), dout_b, eb);
            chk(ser ? "R8" : "R1", $sformatf("first_data bit %0d", k), first_data, ef);
            sclk = 1'b0;
            settle();
            sclk = 1'b1;
            settle();
        end
        cs_n = 1'b1;
        settle();
        chk("R2", "dout_a after cs rise", dout_a, 1'b0);
        chk("R2", "dout_b after cs rise", dout_b, 1'b0);
        chk("R2", "first_data after cs rise", first_data, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; mode_sel = 1'b1; byte_sel = 1'b0; one_lane = 1'b0;
        busy = 1'b0; cs_n = 1'b1; sclk = 1'b1; results = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        settle();
        chk("R10", "dout_a after reset", dout_a, 1'b0);
        chk("R10", "dout_b after reset", dout_b, 1'b0);
        chk("R10", "first_data after reset", first_data, 1'b0);

        // R5 and R7: two-lane read running past the end
        convert(16'hA5C3);
        read_frame(1'b0, HALF * W + 8, 1'b1);
        // R6 and R7: single-lane read of all channels and beyond
        read_frame(1'b1, NCH * W + 8, 1'b1);

        // R9: results change without a busy edge, then while busy is high
        @(negedge clk);
        drive_results(16'h3C71);
        read_frame(1'b0, 40, 1'b1);
        busy = 1'b1;
        drive_results(16'h0F0F);
        read_frame(1'b1, 40, 1'b1);
        // R9: the falling busy now captures the new words
        busy = 1'b0;
        for (int i = 0; i < NCH; i++) exp_words[i] = pattern(16'h0F0F, i);
        settle();
        // R2: partial frame, then a fresh frame restarts at channel 1
        read_frame(1'b0, 20, 1'b1);
        read_frame(1'b0, HALF * W, 1'b1);

        // R1: straps off leave every output quiet
        mode_sel = 1'b0;
        read_frame(1'b0, 24, 1'b0);
        mode_sel = 1'b1; byte_sel = 1'b1;
        read_frame(1'b1, 24, 1'b0);
        byte_sel = 1'b0;
        convert(16'h5A18);
        read_frame(1'b1, NCH * W, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule